// File: doc/BRIEF.md
# Memory-Mapped Address Decoder

This block sits between a processor's data port and the storage behind it. It takes one address and one load request, and it sends that request to exactly one destination. The destination is either a data RAM or one of sixteen single-word I/O registers. In the same pass it chooses which read word goes back to the processor. The RAM array and the registers live outside the block. The block only produces write strobes and multiplexes read data. It has no clock and no state: every output follows the inputs combinationally.

The RAM occupies words 0 to 3839 (0x0000–0x0EFF). That window does not end on a power-of-two boundary. The register window holds slots 0 to 15 at 0x1000–0x100F. In the system this block serves, slot 0 drives the LEDs (1 lights a LED) and slot 1 returns the buttons (0 means pressed). Slots 2 to 10 are kept for further devices, and slots 11 to 15 hold debug values. Addresses that belong to neither window return the RAM read word and never raise a strobe.

Top module: `mem_map_decoder`

## Requirements
- R1: `ram_we_o` equals `load_i` whenever `addr_i` is 3839 or less.
- R2: For an address 0x1000+k with k in 0..15, bit k of `io_we_o` equals `load_i`, and every other bit of `io_we_o` is 0.
- R3: For addresses 0x0F00–0x0FFF and for addresses above 0x100F, `ram_we_o` is 0 and `io_we_o` is all zeros, whatever `load_i` is.
- R4: While `load_i` is 0, `ram_we_o` is 0 and `io_we_o` is all zeros.
- R5: At most one of the 17 strobes (`ram_we_o` and the bits of `io_we_o`) is high at any time.
- R6: For an address 0x1000+k, `rdata_o` equals slot k of `io_rdata_i`, which is bits [16k+15:16k].
- R7: For every address outside 0x1000–0x100F, including the unmapped ones, `rdata_o` equals `ram_rdata_i`.
- R8: The outputs are combinational. A change on the inputs shows on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Word address of the access |
| load_i | input | 1 | Write request for the addressed word |
| ram_rdata_i | input | 16 | Read word from the RAM |
| io_rdata_i | input | 256 | Read words of the 16 I/O slots; slot k is at bits [16k+15:16k] |
| ram_we_o | output | 1 | Write strobe to the RAM |
| io_we_o | output | 16 | Write strobes to the I/O slots; bit k goes to slot k |
| rdata_o | output | 16 | Read word selected by the address |

## Verification
The bound checker watches every input change. It checks that the strobes stay one-hot-or-zero, that the RAM strobe agrees with the window limit, that gap addresses and idle requests stay silent, and that the read word comes from the right source. Some behaviour only the bench can show: the exact edge cases at 3839/3840, 0x0FFF/0x1000 and 0x100F/0x1010; that all sixteen slots are reached one by one; and that outputs settle between clock edges rather than on one.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned DEF_ADDR_W    = 16;
  localparam int unsigned DEF_DATA_W    = 16;
  localparam int unsigned DEF_RAM_WORDS = 3840;
  localparam int unsigned DEF_IO_BASE   = 32'h1000;
  localparam int unsigned DEF_IO_COUNT  = 16;
endpackage

// File: rtl/mmd_ram_window.sv
module mmd_ram_window #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_WORDS = 3840
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_WORDS - 1);

  assign hit_o = (addr_i <= RAM_LAST);
endmodule

// File: rtl/mmd_io_window.sv
module mmd_io_window #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_BASE  = 32'h1000,
  parameter int unsigned IO_COUNT = 16
) (
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        hit_o,
  output logic [IO_COUNT-1:0]         sel_o,
  output logic [$clog2(IO_COUNT)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(IO_COUNT);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(IO_BASE);

  // base is aligned to IO_COUNT, so the page compare ignores the low bits
  assign hit_o = (addr_i[ADDR_W-1:IDX_W] == BASE_A[ADDR_W-1:IDX_W]);
  assign idx_o = addr_i[IDX_W-1:0];

  for (genvar k = 0; k < IO_COUNT; k++) begin : g_slot
    assign sel_o[k] = hit_o && (addr_i[IDX_W-1:0] == IDX_W'(k));
  end
endmodule

// File: rtl/mmd_read_mux.sv
module mmd_read_mux #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IO_COUNT = 16
) (
  input  logic                        io_hit_i,
  input  logic [$clog2(IO_COUNT)-1:0] idx_i,
  input  logic [DATA_W-1:0]           ram_rdata_i,
  input  logic [IO_COUNT*DATA_W-1:0]  io_rdata_i,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [DATA_W-1:0] slot [IO_COUNT];

  for (genvar k = 0; k < IO_COUNT; k++) begin : g_unpack
    assign slot[k] = io_rdata_i[k*DATA_W +: DATA_W];
  end

  assign rdata_o = io_hit_i ? slot[idx_i] : ram_rdata_i;
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned RAM_WORDS = DEF_RAM_WORDS,
  parameter int unsigned IO_BASE   = DEF_IO_BASE,
  parameter int unsigned IO_COUNT  = DEF_IO_COUNT
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       load_i,
  input  logic [DATA_W-1:0]          ram_rdata_i,
  input  logic [IO_COUNT*DATA_W-1:0] io_rdata_i,
  output logic                       ram_we_o,
  output logic [IO_COUNT-1:0]        io_we_o,
  output logic [DATA_W-1:0]          rdata_o
);
  localparam int unsigned IDX_W = $clog2(IO_COUNT);

  logic              ram_hit;
  logic              io_hit;
  logic [IO_COUNT-1:0] io_sel;
  logic [IDX_W-1:0]  io_idx;

  mmd_ram_window #(.ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS)) u_ram_win (
    .addr_i (addr_i),
    .hit_o  (ram_hit)
  );

  mmd_io_window #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_COUNT(IO_COUNT)) u_io_win (
    .addr_i (addr_i),
    .hit_o  (io_hit),
    .sel_o  (io_sel),
    .idx_o  (io_idx)
  );

  assign ram_we_o = load_i & ram_hit;
  assign io_we_o  = {IO_COUNT{load_i}} & io_sel;

  mmd_read_mux #(.DATA_W(DATA_W), .IO_COUNT(IO_COUNT)) u_rmux (
    .io_hit_i    (io_hit),
    .idx_i       (io_idx),
    .ram_rdata_i (ram_rdata_i),
    .io_rdata_i  (io_rdata_i),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/mem_map_decoder_chk.sv
module mem_map_decoder_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RAM_WORDS = 3840,
  parameter int unsigned IO_BASE   = 32'h1000,
  parameter int unsigned IO_COUNT  = 16
) (
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       load_i,
  input logic [DATA_W-1:0]          ram_rdata_i,
  input logic [IO_COUNT*DATA_W-1:0] io_rdata_i,
  input logic                       ram_we_o,
  input logic [IO_COUNT-1:0]        io_we_o,
  input logic [DATA_W-1:0]          rdata_o
);
  localparam int unsigned IDX_W = $clog2(IO_COUNT);
  localparam logic [ADDR_W-1:0] RAM_END = ADDR_W'(RAM_WORDS);
  localparam logic [ADDR_W-1:0] IO_LO   = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] IO_HI   = ADDR_W'(IO_BASE + IO_COUNT - 1);

  logic              in_io;
  logic              in_ram;
  logic [ADDR_W-1:0] off;

  assign in_io  = (addr_i >= IO_LO) && (addr_i <= IO_HI);
  assign in_ram = (addr_i < RAM_END);
  assign off    = addr_i - IO_LO;

  always_comb begin
    if (in_ram) AST_RAM_STROBE: assert (ram_we_o == load_i); // R1
    if (in_io) AST_IO_STROBE: assert (io_we_o == (load_i ? (IO_COUNT'(1) << off[IDX_W-1:0]) : '0)); // R2
    if (!in_ram && !in_io) AST_GAP_SILENT: assert (!ram_we_o && io_we_o == '0); // R3
    if (!load_i) AST_IDLE_SILENT: assert (!ram_we_o && io_we_o == '0); // R4
    AST_ONE_STROBE: assert ($onehot0({ram_we_o, io_we_o})); // R5
    if (in_io) AST_IO_READ: assert (rdata_o == io_rdata_i[off[IDX_W-1:0]*DATA_W +: DATA_W]); // R6
    if (!in_io) AST_RAM_READ: assert (rdata_o == ram_rdata_i); // R7
  end
endmodule

bind mem_map_decoder mem_map_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_WORDS(RAM_WORDS),
  .IO_BASE(IO_BASE), .IO_COUNT(IO_COUNT)
) u_chk (
  .addr_i      (addr_i),
  .load_i      (load_i),
  .ram_rdata_i (ram_rdata_i),
  .io_rdata_i  (io_rdata_i),
  .ram_we_o    (ram_we_o),
  .io_we_o     (io_we_o),
  .rdata_o     (rdata_o)
);

// File: tb/mem_map_decoder_tb.sv
module mem_map_decoder_tb;
  logic         clk = 1'b0;
  logic [15:0]  addr;
  logic         load;
  logic [15:0]  ram_rd;
  logic [15:0]  io_mem [16];
  logic [255:0] io_rd;
  logic         ram_we;
  logic [15:0]  io_we;
  logic [15:0]  rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  always_comb
    for (int k = 0; k < 16; k++) io_rd[k*16 +: 16] = io_mem[k];

  mem_map_decoder u_dut (
    .addr_i      (addr),
    .load_i      (load),
    .ram_rdata_i (ram_rd),
    .io_rdata_i  (io_rd),
    .ram_we_o    (ram_we),
    .io_we_o     (io_we),
    .rdata_o     (rdata)
  );

  function automatic bit in_io(input logic [15:0] a);
    return a >= 16'h1000 && a <= 16'h100F;
  endfunction

  function automatic logic exp_ram_we(input logic [15:0] a, input logic l);
    return l && a <= 16'd3839;
  endfunction

  function automatic logic [15:0] exp_io_we(input logic [15:0] a, input logic l);
    logic [15:0] v = '0;
    if (l && in_io(a)) v[a - 16'h1000] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [15:0] a);
    return in_io(a) ? io_mem[a - 16'h1000] : ram_rd;
  endfunction

  function automatic string tag_we(input logic [15:0] a, input logic l);
    if (!l) return "R4";
    if (a <= 16'd3839) return "R1";
    if (in_io(a)) return "R2";
    return "R3";
  endfunction

  task automatic check_now(input string why);
    string t = tag_we(addr, load);
    n_run++;
    if (ram_we !== exp_ram_we(addr, load)) begin
      n_fail++;
      $display("FAIL %s %s ram_we addr=%h load=%0b got=%0b exp=%0b", t, why, addr, load, ram_we, exp_ram_we(addr, load));
    end
    n_run++;
    if (io_we !== exp_io_we(addr, load)) begin
      n_fail++;
      $display("FAIL %s %s io_we addr=%h got=%h exp=%h", t, why, addr, io_we, exp_io_we(addr, load));
    end
    n_run++;
    if ($countones({ram_we, io_we}) > 1) begin
      n_fail++;
      $display("FAIL R5 %s strobes addr=%h got=%0d exp<=1", why, addr, $countones({ram_we, io_we}));
    end
    n_run++;
    if (rdata !== exp_rdata(addr)) begin
      n_fail++;
      $display("FAIL %s %s rdata addr=%h got=%h exp=%h", in_io(addr) ? "R6" : "R7", why, addr, rdata, exp_rdata(addr));
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic l, input string why);
    @(posedge clk);
    addr   = a;
    load   = l;
    ram_rd = 16'($urandom);
    for (int k = 0; k < 16; k++) io_mem[k] = 16'($urandom);
    @(negedge clk);
    check_now(why);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    addr = '0; load = 1'b0; ram_rd = 16'hA5A5;
    for (int k = 0; k < 16; k++) io_mem[k] = 16'(k * 16'h1111);
    #1;
    check_now("initial R4");

    // directed edges
    for (int l = 0; l < 2; l++) begin
      apply(16'd0,    l[0], "R1 low");
      apply(16'd3839, l[0], "R1 last");
      apply(16'd3840, l[0], "R3 past ram");
      apply(16'h0FFF, l[0], "R3 gap top");
      apply(16'h1010, l[0], "R3 past io");
      apply(16'hFFFF, l[0], "R3 top");
      for (int k = 0; k < 16; k++) apply(16'h1000 + 16'(k), l[0], "R2 R6 slot");
    end

    // R8: change inputs between edges, check without an edge
    @(negedge clk);
    addr = 16'h100B; load = 1'b1; #1;
    check_now("R8 between edges");
    addr = 16'd100; #1;
    check_now("R8 between edges");

    // random, biased toward window edges
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      case ($urandom_range(3))
        0: a = 16'($urandom);
        1: a = 16'($urandom_range(3839));
        2: a = 16'h1000 + 16'($urandom_range(16));
        default: a = 16'h0EF0 + 16'($urandom_range(16'h0130));
      endcase
      apply(a, 1'($urandom), "random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule